// File: doc/BRIEF.md
# I/O-Mapped Port Registers with Hex Display Source

This block sits on an 8-bit processor bus and provides three byte-wide registers in I/O space at consecutive port addresses starting at 50h. The processor can load any of them with an output instruction and read any of them back with an input instruction, at any time. The lowest register drives eight open-drain pins that have external pull-ups. A 0 bit pulls its pin low. A 1 bit releases the pin, so it can serve as an input. A read of that register returns the level present on the pins, not the stored value.

The block also selects what six hex digits show. With the select low, the three registers are shown, highest address in the top two digits. With the select high, the digits show the address and data of the last completed memory or I/O transfer. That snapshot stays stable while the processor is stalled, for example when it is single-stepped. Segment decoding and digit scanning are handled elsewhere.

Bus signals are taken as already synchronised to `clk`. The open-drain pins and the data bus are split into separate in, out and enable ports, which pad cells combine.

Top module: `pio_display_top`

## Requirements
- R1: A port access is decoded only when IOREQ is low and M1 is high, on the low address byte alone, for 50h, 51h or 52h. Address bits 15..8 are ignored. Any other low byte (e.g. 53h) neither writes nor drives the bus.
- R2: On the clock after WR rises at the end of a decoded write, the addressed register holds the data the bus carried before the rise. The other two registers keep their values.
- R3: `pio_drive_low[i]` is 1 exactly when bit i of register 50h is 0.
- R4: A read of 50h returns `pio_in`. A read of 51h or 52h returns the stored register value.
- R5: `d_oe` is 1 only while IOREQ and RD are low, M1 is high, and the low address byte hits one of the three ports. `d_oe` is 0 at all other times.
- R6: After reset all three registers hold FFh, so no pin is pulled low and every digit shows F in register mode. The bus snapshot is 000000h.
- R7: With `disp_sel`=0, `dig5,dig4` show register 52h (high nibble first), `dig3,dig2` show 51h and `dig1,dig0` show 50h.
- R8: With `disp_sel`=1, `dig5..dig2` show the snapshot address bits 15..0 (high nibble first), and `dig1,dig0` show the snapshot data.
- R9: The snapshot is reloaded only on the clock after a transfer ends. A transfer is MREQ low, or IOREQ low with M1 high, together with RD or WR low. The address and bus data of the transfer's last cycle are stored. Refresh cycles and an unfinished transfer leave the snapshot unchanged.
- R10: An interrupt acknowledge cycle (IOREQ and M1 both low) neither drives the bus nor writes a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| d_in | input | 8 | Resolved data bus value |
| d_out | output | 8 | Read data for the bus |
| d_oe | output | 1 | Drive enable for `d_out` |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| pio_in | input | 8 | Sensed level of the open-drain pins |
| pio_drive_low | output | 8 | Per-pin pull-down enable |
| disp_sel | input | 1 | 0: registers, 1: bus snapshot |
| dig0 | output | 4 | Lowest display digit |
| dig1 | output | 4 | Display digit 1 |
| dig2 | output | 4 | Display digit 2 |
| dig3 | output | 4 | Display digit 3 |
| dig4 | output | 4 | Display digit 4 |
| dig5 | output | 4 | Highest display digit |

## Verification
A corrupted register shows on the register-mode digits and, for 50h, on `pio_drive_low` one clock after the faulty write. It also shows at `d_out` on the next read of that port. A snapshot that loads at the wrong time shows in bus mode either as digits changing during a refresh or a stall, or as digits still stale on the first clock after a transfer closes. A decode fault shows at once as `d_oe` rising on an acknowledge cycle or on a foreign port.

// File: rtl/pio_disp_pkg.sv
package pio_disp_pkg;
  parameter int AW        = 16;
  parameter int DW        = 8;
  parameter int NREG      = 3;
  parameter int NDIG      = 6;
  parameter logic [7:0] BASE_PORT = 8'h50;
  localparam int SNAPW    = AW + DW;
  localparam int FILEW    = NREG * DW;
  typedef logic [NREG-1:0][DW-1:0] reg_file_t;
  typedef logic [NDIG-1:0][3:0]    digit_vec_t;
endpackage

// File: rtl/pio_bus_dec.sv
module pio_bus_dec
  import pio_disp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_in,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          m1_n,
  input  reg_file_t     regs,
  input  logic [DW-1:0] pio_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  output logic [NREG-1:0] wr_stb,
  output logic [DW-1:0] wr_data
);
  logic [NREG-1:0] hit;
  logic            io_cyc;
  logic [NREG-1:0] hit_q, hit_d;
  logic            wr_n_q;
  logic [DW-1:0]   data_q;

  assign io_cyc = ~iorq_n & m1_n;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = io_cyc && (addr[7:0] == BASE_PORT + 8'(i));
  end

  always_comb begin
    hit_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      wr_n_q <= 1'b1;
      data_q <= '0;
    end else begin
      hit_q  <= hit_d;
      wr_n_q <= wr_n;
      data_q <= d_in;
    end
  end

  assign wr_stb  = hit_q & {NREG{wr_n & ~wr_n_q}};
  assign wr_data = data_q;

  always_comb begin
    d_out = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) d_out = (i == 0) ? pio_in : regs[i];
    end
  end

  assign d_oe = ~rd_n & (|hit);

  AST_DOE_NEEDS_IOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (!iorq_n && !rd_n)); // R5
  AST_NO_DRIVE_INTA: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> m1_n); // R10
endmodule

// File: rtl/pio_reg_file.sv
module pio_reg_file
  import pio_disp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] wr_stb,
  input  logic [DW-1:0]   wr_data,
  output reg_file_t       regs
);
  reg_file_t regs_d;

  always_comb begin
    regs_d = regs;
    for (int i = 0; i < NREG; i++) begin
      if (wr_stb[i]) regs_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '1;
    else if (|wr_stb) regs <= regs_d;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)); // R2
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_stb) |=> $stable(regs)); // R2
endmodule

// File: rtl/pio_disp_src.sv
module pio_disp_src
  import pio_disp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d_in,
  input  logic          mreq_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          m1_n,
  input  logic          disp_sel,
  input  reg_file_t     regs,
  output digit_vec_t    digits
);
  logic             xfer;
  logic             xfer_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [SNAPW-1:0] snap, snap_d;
  logic             snap_ld;
  logic [SNAPW-1:0] src;

  assign xfer    = (~mreq_n | (~iorq_n & m1_n)) & (~rd_n | ~wr_n);
  assign snap_ld = xfer_q & ~xfer;

  always_comb begin
    snap_d = snap;
    if (snap_ld) snap_d = {addr_q, data_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      xfer_q <= xfer;
      addr_q <= addr;
      data_q <= d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (snap_ld) snap <= snap_d;
  end

  assign src = disp_sel ? snap : SNAPW'(regs);

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign digits[g] = src[4*g +: 4];
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_ld |=> $stable(snap)); // R9
endmodule

// File: rtl/pio_display_top.sv
module pio_display_top
  import pio_disp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   addr,
  input  logic [7:0]    d_in,
  output logic [7:0]    d_out,
  output logic          d_oe,
  input  logic          mreq_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          m1_n,
  input  logic [7:0]    pio_in,
  output logic [7:0]    pio_drive_low,
  input  logic          disp_sel,
  output logic [3:0]    dig0,
  output logic [3:0]    dig1,
  output logic [3:0]    dig2,
  output logic [3:0]    dig3,
  output logic [3:0]    dig4,
  output logic [3:0]    dig5
);
  logic [1:0]      rst_sync;
  logic            rst_sync_n;
  reg_file_t       regs;
  logic [NREG-1:0] wr_stb;
  logic [DW-1:0]   wr_data;
  digit_vec_t      digits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  pio_bus_dec u_dec (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .d_in(d_in),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .regs(regs), .pio_in(pio_in), .d_out(d_out), .d_oe(d_oe),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  pio_reg_file u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb),
    .wr_data(wr_data), .regs(regs)
  );

  pio_disp_src u_disp (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .d_in(d_in),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .disp_sel(disp_sel), .regs(regs), .digits(digits)
  );

  assign pio_drive_low = ~regs[0];
  assign dig0 = digits[0];
  assign dig1 = digits[1];
  assign dig2 = digits[2];
  assign dig3 = digits[3];
  assign dig4 = digits[4];
  assign dig5 = digits[5];

  AST_PINS_FREE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (pio_drive_low == 8'h00)); // R6
endmodule

// File: tb/tb_pio_display_top.sv
`timescale 1ns/1ps
module tb_pio_display_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [15:0] addr;
  logic [7:0] drv_d, d_in, d_out, pio_in, pio_drive_low, ext_lvl;
  logic d_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n, disp_sel;
  logic [3:0] dig0, dig1, dig2, dig3, dig4, dig5;

  assign d_in   = d_oe ? d_out : drv_d;
  assign pio_in = ext_lvl & ~pio_drive_low;

  pio_display_top dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .d_in(d_in), .d_out(d_out),
    .d_oe(d_oe), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .pio_in(pio_in),
    .pio_drive_low(pio_drive_low), .disp_sel(disp_sel),
    .dig0(dig0), .dig1(dig1), .dig2(dig2), .dig3(dig3),
    .dig4(dig4), .dig5(dig5)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mreg [3];
  int msnap;
  bit p_wr_n, p_xfer, p_hit;
  int p_addr, p_data, p_idx;
  bit mon_on = 0;

  function automatic int rd_val(int a);
    int lo = a & 255;
    if (lo == 'h50) return ext_lvl & mreg[0];
    return mreg[lo - 'h50];
  endfunction

  always @(posedge clk) begin
    int lo, bus;
    bit hit, xfer, oe;
    lo   = addr & 255;
    hit  = !iorq_n && m1_n && lo >= 'h50 && lo <= 'h52;
    oe   = hit && !rd_n;
    bus  = oe ? rd_val(addr) : drv_d;
    xfer = (!mreq_n || (!iorq_n && m1_n)) && (!rd_n || !wr_n);
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) mreg[i] = 'hFF;
      msnap = 0; p_wr_n = 1; p_xfer = 0; p_hit = 0; p_addr = 0; p_data = 0; p_idx = 0;
    end else begin
      if (!p_wr_n && wr_n && p_hit) mreg[p_idx] = p_data;
      if (p_xfer && !xfer) msnap = (p_addr << 8) | p_data;
      p_wr_n = wr_n; p_xfer = xfer; p_hit = hit; p_idx = lo - 'h50;
      p_addr = addr; p_data = bus;
    end
    #1;
    if (mon_on) begin
      int exp_dig, act_dig;
      act_dig = {dig5, dig4, dig3, dig2, dig1, dig0};
      exp_dig = disp_sel ? msnap : ((mreg[2] << 16) | (mreg[1] << 8) | mreg[0]);
      chk(act_dig == exp_dig, disp_sel ? "R8 bus digits" : "R7 register digits", act_dig, exp_dig);
      chk(pio_drive_low == (~mreg[0] & 255), "R3 pin drive", pio_drive_low, ~mreg[0] & 255);
      lo  = addr & 255;
      oe  = !iorq_n && m1_n && !rd_n && lo >= 'h50 && lo <= 'h52;
      chk(d_oe == oe, "R5 drive enable", d_oe, oe);
      if (oe) chk(d_out == rd_val(addr), "R4 read data", d_out, rd_val(addr));
    end
  end

  task automatic idle();
    @(negedge clk);
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic m1v);
    @(negedge clk);
    addr = a; drv_d = d; iorq_n = 0; m1_n = m1v; wr_n = 0;
    repeat (2) @(negedge clk);
    iorq_n = 1; wr_n = 1; m1_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic io_read(input logic [15:0] a, input logic m1v,
                         input bit exp_oe, input logic [7:0] exp_d, input string tag);
    @(negedge clk);
    addr = a; drv_d = 8'h00; iorq_n = 0; m1_n = m1v; rd_n = 0;
    @(posedge clk); #1;
    chk(d_oe == exp_oe, tag, d_oe, exp_oe);
    if (exp_oe) chk(d_out == exp_d, tag, d_out, exp_d);
    @(negedge clk);
    iorq_n = 1; rd_n = 1; m1_n = 1;
    @(negedge clk);
  endtask

  task automatic mem_read(input logic [15:0] a, input logic [7:0] d, input int cyc);
    @(negedge clk);
    addr = a; drv_d = d; mreq_n = 0; rd_n = 0;
    repeat (cyc) @(negedge clk);
    mreq_n = 1; rd_n = 1;
  endtask

  function automatic logic [23:0] digs();
    return {dig5, dig4, dig3, dig2, dig1, dig0};
  endfunction

  initial begin
    #(4 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; addr = 0; drv_d = 0; mreq_n = 1; iorq_n = 1; rd_n = 1;
    wr_n = 1; m1_n = 1; disp_sel = 0; ext_lvl = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk(digs() == 24'hFFFFFF, "R6 reset digits", digs(), 24'hFFFFFF);
    chk(pio_drive_low == 8'h00, "R6 pins released", pio_drive_low, 0);
    chk(d_oe == 0, "R6 no drive", d_oe, 0);
    disp_sel = 1;
    @(negedge clk);
    chk(digs() == 24'h000000, "R6 snapshot clear", digs(), 0);
    disp_sel = 0;
    mon_on = 1;

    // R2 writes, R7 layout, R3 pins
    io_write(16'h0050, 8'h5A, 1);
    io_write(16'h0051, 8'h12, 1);
    io_write(16'h0052, 8'h34, 1);
    chk(digs() == 24'h34125A, "R7 layout", digs(), 24'h34125A);
    chk(pio_drive_low == 8'hA5, "R3 drive low", pio_drive_low, 8'hA5);
    io_write(16'h0051, 8'hC7, 1);
    chk(digs() == 24'h34C75A, "R2 only addressed reg", digs(), 24'h34C75A);

    // R4 reads
    io_read(16'h0051, 1, 1, 8'hC7, "R4 read 51h");
    io_read(16'h0052, 1, 1, 8'h34, "R4 read 52h");
    io_read(16'h0050, 1, 1, 8'h5A, "R4 read 50h pins high");
    ext_lvl = 8'hF0;
    io_read(16'h0050, 1, 1, 8'h50, "R4 read 50h external low");
    ext_lvl = 8'hFF;

    // R1 decoding on low byte
    io_write(16'hAB51, 8'h77, 1);
    chk(digs() == 24'h34775A, "R1 upper address ignored", digs(), 24'h34775A);
    io_write(16'h0053, 8'h00, 1);
    chk(digs() == 24'h34775A, "R1 foreign port no write", digs(), 24'h34775A);
    io_read(16'h0053, 1, 0, 8'h00, "R1 foreign port no drive");
    io_read(16'h9952, 1, 1, 8'h34, "R1 high byte ignored on read");

    // R10 interrupt acknowledge
    io_read(16'h0050, 0, 0, 8'h00, "R10 acknowledge no drive");
    io_write(16'h0052, 8'h00, 0);
    chk(digs() == 24'h34775A, "R10 acknowledge no write", digs(), 24'h34775A);

    // R8 / R9 bus display mode
    disp_sel = 1;
    @(negedge clk);
    mem_read(16'hA5C3, 8'h9E, 3);
    @(negedge clk);
    chk(digs() == 24'hA5C39E, "R9 snapshot after memory read", digs(), 24'hA5C39E);
    @(negedge clk);
    addr = 16'h1111; drv_d = 8'h22; mreq_n = 0;
    repeat (3) @(negedge clk);
    mreq_n = 1;
    @(negedge clk);
    chk(digs() == 24'hA5C39E, "R9 refresh ignored", digs(), 24'hA5C39E);
    addr = 16'h4242; drv_d = 8'h66; mreq_n = 0; rd_n = 0;
    repeat (5) @(negedge clk);
    chk(digs() == 24'hA5C39E, "R9 held during stall", digs(), 24'hA5C39E);
    mreq_n = 1; rd_n = 1;
    @(negedge clk);
    chk(digs() == 24'h424266, "R8 memory snapshot", digs(), 24'h424266);
    io_read(16'h3352, 1, 1, 8'h34, "R4 read in bus mode");
    chk(digs() == 24'h335234, "R8 I/O read snapshot", digs(), 24'h335234);
    io_write(16'h0750, 8'hFF, 1);
    chk(digs() == 24'h0750FF, "R9 I/O write snapshot", digs(), 24'h0750FF);
    disp_sel = 0;
    @(negedge clk);
    chk(digs() == 24'h3477FF, "R7 back to registers", digs(), 24'h3477FF);
    chk(pio_drive_low == 8'h00, "R3 all released", pio_drive_low, 0);

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule